// File: doc/BRIEF.md
# Key Matrix Scanner with Read Request

This block serves a keypad wired as a grid: six scan lines drive the rows and five return inputs, each pulled low outside the block, sense the columns. It stays quiet until a pressed key pulls a return high. Then it sweeps the rows one at a time, sweeps them a second time, and compares the two images. A matching, non-empty image is copied into a 30-bit key register, and an active-low request goes to the host. Two sweeps that differ start the whole run again. So a key must be held steady for a full confirmation window before the host sees it.

The host can give scan rows 1 and 2 over to another use. Those lines are then held low and their key bits read as zero. A two-bit sleep code sets which lines idle high while the block waits. In normal mode all lines idle high and the oscillator-enable output stays on. In the sleep codes only some lines idle high, and a press on one of those lines raises the oscillator enable and starts a sweep. A flag records whether the press that started the run came in while asleep.

The host pulses a read-done strobe after it has taken the data. This drops the request and starts a new run. The new run either reports the keys still held or, if none are held, clears the key register and returns to standby.

Top module: `keyscan_matrix`

## Requirements
- R1: While waiting for a press, the scan lines idle at levels set by `sleep_code`: 00 drives all six high, 01 drives only line 6 (bit 5) high, 10 drives lines 5 and 6 (bits 5:4) high, and 11 drives all six high.
- R2: `seg_sel` 00 leaves every row for scanning. 01 gives row 1 (bit 0) away, and 10 or 11 gives rows 1 and 2 (bits 1:0) away. A row given away is always driven low, and its five key bits read 0.
- R3: A run starts only when a return input is high while the block waits. `osc_en` is high in normal mode (code 00) or while a run or request is in progress. It is low while the block waits in a sleep code, so a press on a line idling low changes nothing.
- R4: During a sweep, exactly one enabled row is high at a time. The rows go from line 1 to line 6, and each holds for `SLOT_TICKS` oscillator ticks.
- R5: The key bit for row r (1..6) and column c (1..5) is number 5*(r-1)+c. It appears at `key_data` bit 5*(r-1)+c-1, and several held keys set several bits.
- R6: When both sweeps agree and are non-empty, `req_n` falls exactly `CONFIRM_TICKS` ticks after the run started.
- R7: When the two sweeps differ, the run starts over, and the request comes `2*CONFIRM_TICKS` ticks after the original start.
- R8: `req_n` is high whenever `ce` is high, and returns low when `ce` drops while a request is pending.
- R9: A `rd_done` pulse during a pending request releases `req_n` on the next clock and starts a new run. A run whose sweeps agree on no keys clears `key_data`, raises no request and returns to standby.
- R10: `sleep_ack` is 1 when the run began under a non-zero sleep code and 0 when it began in normal mode.
- R11: An active-low `rst_n` clears `key_data`, holds `req_n` high and puts the block in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| key_ret | input | 5 | Column return inputs, high when a key on a driven row is pressed |
| sleep_code | input | 2 | 00 normal, otherwise a sleep standby pattern |
| seg_sel | input | 2 | Selects rows given away from scanning |
| ce | input | 1 | Host transfer active; releases the request |
| rd_done | input | 1 | One-cycle strobe: host finished reading keys |
| scan_line | output | 6 | Row drive lines |
| key_data | output | 30 | Confirmed key image |
| sleep_ack | output | 1 | Run began while asleep |
| req_n | output | 1 | Read request, active low |
| osc_en | output | 1 | Oscillator run enable |

## Verification
A wrong row counter or slot counter shows on `scan_line` within one slot, because a bit lands in the wrong place or two rows are driven at once. A wrong pass buffer or comparison shows only when the request falls, about `CONFIRM_TICKS` ticks later. The fault then appears as a request timed at one window instead of two, or the reverse, or as wrong bits in `key_data`. A fault in the state register shows at once on `req_n` or `osc_en`. The bench therefore times each request to the exact clock and checks the line pattern inside the first two slots.

// File: rtl/ksm_pkg.sv
package ksm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } ksm_state_e;

  localparam int unsigned MASK_W = 32;

  function automatic logic [MASK_W-1:0] all_rows(input int unsigned rows);
    return (MASK_W'(1) << rows) - MASK_W'(1);
  endfunction

  // idle drive pattern for each sleep code; the top lines always stay high
  function automatic logic [MASK_W-1:0] standby_levels(input logic [1:0] code,
                                                       input int unsigned rows);
    case (code)
      2'b01:   return MASK_W'(1) << (rows - 1);
      2'b10:   return MASK_W'(3) << (rows - 2);
      default: return all_rows(rows);
    endcase
  endfunction

  // rows still used for scanning after the low rows are given away
  function automatic logic [MASK_W-1:0] row_enable(input logic [1:0] sel,
                                                   input int unsigned rows);
    case (sel)
      2'b00:   return all_rows(rows);
      2'b01:   return all_rows(rows) & ~MASK_W'(1);
      default: return all_rows(rows) & ~MASK_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/ksm_timer.sv
module ksm_timer #(
  parameter int unsigned ROWS          = 6,
  parameter int unsigned SLOT_TICKS    = 62,
  parameter int unsigned CONFIRM_TICKS = 800
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    restart,
  input  logic                    tick,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic                    pass_sel,
  output logic                    sweep,
  output logic                    slot_end,
  output logic                    confirm
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned SW = $clog2(SLOT_TICKS);
  localparam int unsigned TW = $clog2(CONFIRM_TICKS);

  logic [SW-1:0] slot_q;
  logic [TW-1:0] tcnt_q;
  logic [RW-1:0] row_q;
  logic [1:0]    pass_q;

  assign sweep    = (pass_q != 2'd2);
  assign row_idx  = row_q;
  assign pass_sel = pass_q[0];
  assign slot_end = run && tick && sweep && (slot_q == SW'(SLOT_TICKS - 1));
  assign confirm  = run && tick && (tcnt_q == TW'(CONFIRM_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      tcnt_q <= '0;
      row_q  <= '0;
      pass_q <= '0;
    end else if (!run || restart) begin
      slot_q <= '0;
      tcnt_q <= '0;
      row_q  <= '0;
      pass_q <= '0;
    end else if (tick) begin
      if (tcnt_q != TW'(CONFIRM_TICKS - 1)) tcnt_q <= tcnt_q + 1'b1;
      if (sweep) begin
        if (slot_q == SW'(SLOT_TICKS - 1)) begin
          slot_q <= '0;
          if (row_q == RW'(ROWS - 1)) begin
            row_q  <= '0;
            pass_q <= pass_q + 2'd1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ksm_capture.sv
module ksm_capture #(
  parameter int unsigned ROWS = 6,
  parameter int unsigned COLS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(ROWS)-1:0] row_idx,
  input  logic                    pass_sel,
  input  logic                    slot_end,
  input  logic [ROWS-1:0]         row_en,
  input  logic [COLS-1:0]         key_ret,
  input  logic                    commit,
  output logic                    match,
  output logic                    empty,
  output logic [ROWS*COLS-1:0]    key_data
);
  localparam int unsigned KEYS = ROWS * COLS;

  logic [COLS-1:0] first_q  [ROWS];
  logic [COLS-1:0] second_q [ROWS];
  logic [KEYS-1:0] first_flat, second_flat;
  logic [COLS-1:0] gated;

  assign gated = row_en[row_idx] ? key_ret : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        first_q[r]  <= '0;
        second_q[r] <= '0;
      end
    end else if (slot_end) begin
      if (pass_sel) second_q[row_idx] <= gated;
      else          first_q[row_idx]  <= gated;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign first_flat[r*COLS +: COLS]  = first_q[r];
    assign second_flat[r*COLS +: COLS] = second_q[r];
  end

  assign match = (first_flat == second_flat);
  assign empty = (second_flat == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_data <= '0;
    else if (commit) key_data <= second_flat;
  end
endmodule

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
  import ksm_pkg::*;
#(
  parameter int unsigned ROWS          = 6,
  parameter int unsigned COLS          = 5,
  parameter int unsigned SLOT_TICKS    = 62,
  parameter int unsigned CONFIRM_TICKS = 800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_tick,
  input  logic [COLS-1:0]      key_ret,
  input  logic [1:0]           sleep_code,
  input  logic [1:0]           seg_sel,
  input  logic                 ce,
  input  logic                 rd_done,
  output logic [ROWS-1:0]      scan_line,
  output logic [ROWS*COLS-1:0] key_data,
  output logic                 sleep_ack,
  output logic                 req_n,
  output logic                 osc_en
);
  localparam int unsigned RW = $clog2(ROWS);

  ksm_state_e state_q, state_d;
  logic       sa_q;

  logic [MASK_W-1:0] en_full, idle_full;
  logic [ROWS-1:0]   row_en, idle_lvl;
  logic [RW-1:0]     row_idx;
  logic              pass_sel, sweep, slot_end, confirm, match, empty;

  // named internal events, also observed by the bound checker
  logic idle_w, active_w, hold_w, commit_w, restart_w;

  assign en_full   = row_enable(seg_sel, ROWS);
  assign idle_full = standby_levels(sleep_code, ROWS);
  assign row_en    = en_full[ROWS-1:0];
  assign idle_lvl  = idle_full[ROWS-1:0];

  assign idle_w    = (state_q == ST_IDLE);
  assign hold_w    = (state_q == ST_HOLD);
  assign active_w  = (state_q == ST_SCAN) && sweep;
  assign commit_w  = (state_q == ST_SCAN) && confirm && match;
  assign restart_w = (state_q == ST_SCAN) && confirm && !match;

  ksm_timer #(
    .ROWS(ROWS), .SLOT_TICKS(SLOT_TICKS), .CONFIRM_TICKS(CONFIRM_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SCAN), .restart(restart_w),
    .tick(osc_tick), .row_idx(row_idx), .pass_sel(pass_sel), .sweep(sweep),
    .slot_end(slot_end), .confirm(confirm)
  );

  ksm_capture #(.ROWS(ROWS), .COLS(COLS)) u_capture (
    .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .pass_sel(pass_sel),
    .slot_end(slot_end), .row_en(row_en), .key_ret(key_ret),
    .commit(commit_w), .match(match), .empty(empty), .key_data(key_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (|key_ret) state_d = ST_SCAN;
      ST_SCAN: if (commit_w) state_d = empty ? ST_IDLE : ST_HOLD;
      ST_HOLD: if (rd_done) state_d = ST_SCAN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sa_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle_w && (|key_ret)) sa_q <= (sleep_code != 2'b00);
    end
  end

  always_comb begin
    if (idle_w)        scan_line = idle_lvl & row_en;
    else if (active_w) scan_line = (ROWS'(1) << row_idx) & row_en;
    else               scan_line = '0;
  end

  assign sleep_ack = sa_q;
  assign req_n     = !hold_w || ce;
  assign osc_en    = (sleep_code == 2'b00) || !idle_w;
endmodule

// File: rtl/keyscan_matrix_chk.sv
module ksm_checker #(
  parameter int unsigned ROWS = 6,
  parameter int unsigned KEYS = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce,
  input logic            rd_done,
  input logic [1:0]      sleep_code,
  input logic [1:0]      seg_sel,
  input logic [ROWS-1:0] scan_line,
  input logic [KEYS-1:0] key_data,
  input logic            sleep_ack,
  input logic            req_n,
  input logic            osc_en,
  input logic            idle_w,
  input logic            active_w,
  input logic            hold_w,
  input logic            commit_w
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (req_n && key_data == '0 && idle_w) else $error("reset state"); // R11
    end
  end

  AST_SLEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w && sleep_code == 2'b01 |-> scan_line[ROWS-2:0] == '0) else $error("sleep level"); // R1
  AST_GIVEN_ROWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    seg_sel[1] |-> scan_line[1:0] == 2'b00) else $error("given rows"); // R2
  AST_GIVEN_ROW1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    seg_sel == 2'b01 |-> !scan_line[0]) else $error("given row"); // R2
  AST_QUIET_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w && sleep_code != 2'b00 |-> !osc_en) else $error("osc enable"); // R3
  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    active_w |-> $onehot0(scan_line)) else $error("one row"); // R4
  AST_REQ_HAS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> key_data != '0) else $error("empty request"); // R6
  AST_REQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(commit_w) || $fell(ce)) else $error("request cause"); // R6
  AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> req_n) else $error("ce release"); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w && rd_done |=> req_n) else $error("read clear"); // R9
  AST_SA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w |=> $stable(sleep_ack)) else $error("sa stable"); // R10
endmodule

bind keyscan_matrix ksm_checker #(.ROWS(ROWS), .KEYS(ROWS*COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .rd_done(rd_done), .sleep_code(sleep_code),
  .seg_sel(seg_sel), .scan_line(scan_line), .key_data(key_data),
  .sleep_ack(sleep_ack), .req_n(req_n), .osc_en(osc_en), .idle_w(idle_w),
  .active_w(active_w), .hold_w(hold_w), .commit_w(commit_w)
);

// File: tb/keyscan_matrix_test.sv
`timescale 1ns/1ps
module keyscan_matrix_test;
  localparam int ROWS = 6, COLS = 5, KEYS = 30, SLOT = 62, CONF = 800;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b1, ce = 1'b0, rd_done = 1'b0;
  logic [1:0] sleep_code = 2'b00, seg_sel = 2'b00;
  logic [COLS-1:0] key_ret;
  logic [ROWS-1:0] scan_line;
  logic [KEYS-1:0] key_data, pressed = '0;
  logic sleep_ack, req_n, osc_en;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyscan_matrix #(.ROWS(ROWS), .COLS(COLS), .SLOT_TICKS(SLOT), .CONFIRM_TICKS(CONF)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .key_ret(key_ret),
    .sleep_code(sleep_code), .seg_sel(seg_sel), .ce(ce), .rd_done(rd_done),
    .scan_line(scan_line), .key_data(key_data), .sleep_ack(sleep_ack),
    .req_n(req_n), .osc_en(osc_en));

  // keypad model: a held key connects its row line to its column return
  always_comb begin
    key_ret = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (pressed[r*COLS + c] && scan_line[r]) key_ret[c] = 1'b1;
  end

  function automatic int kbit(input int row, input int col); // 1-based row and column
    return COLS*(row-1) + col - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!req_n) break;
    end
  endtask

  task automatic read_done();
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk) pressed = '0;
    if (!req_n) read_done();
    repeat (2*CONF + 20) @(posedge clk);
    @(negedge clk);
  endtask

  // {sleep_code, seg_sel, expected idle lines}
  localparam logic [9:0] IDLE_VEC [8] = '{
    {2'b00, 2'b00, 6'h3F}, {2'b01, 2'b00, 6'h20}, {2'b10, 2'b00, 6'h30},
    {2'b11, 2'b00, 6'h3F}, {2'b00, 2'b01, 6'h3E}, {2'b00, 2'b10, 6'h3C},
    {2'b11, 2'b11, 6'h3C}, {2'b10, 2'b11, 6'h30}};

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [KEYS-1:0] exp;
    repeat (3) @(negedge clk);
    chk(req_n === 1'b1 && key_data === '0, "R11 reset state", {key_data[30:0], req_n}, 32'h1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 / R3: idle levels and oscillator enable from the vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) {sleep_code, seg_sel} = IDLE_VEC[i][9:6];
      @(negedge clk);
      chk(scan_line === IDLE_VEC[i][5:0], "R1 R2 idle lines", 32'(scan_line), 32'(IDLE_VEC[i][5:0]));
      chk(osc_en === (IDLE_VEC[i][9:8] == 2'b00), "R3 osc_en idle", 32'(osc_en), 32'(IDLE_VEC[i][9:8] == 2'b00));
    end
    @(negedge clk) begin sleep_code = 2'b00; seg_sel = 2'b00; end

    // R4 / R5 / R6 / R10: single key, row 3 column 4
    @(negedge clk) pressed[kbit(3,4)] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(scan_line === 6'h01, "R4 first slot row 1", 32'(scan_line), 32'h01);
    repeat (SLOT-1) @(posedge clk); @(negedge clk);
    chk(scan_line === 6'h01, "R4 last tick of slot 1", 32'(scan_line), 32'h01);
    @(posedge clk); @(negedge clk);
    chk(scan_line === 6'h02, "R4 slot 2 row 2", 32'(scan_line), 32'h02);
    wait_req(n);
    n += SLOT + 1;
    chk(n == CONF + 1, "R6 request timing", 32'(n), 32'(CONF + 1));
    chk(key_data === (30'd1 << kbit(3,4)), "R5 key bit", 32'(key_data), 32'd1 << kbit(3,4));
    chk(sleep_ack === 1'b0, "R10 normal press", 32'(sleep_ack), 32'h0);

    // R8: ce releases the request
    @(negedge clk) ce = 1'b1;
    #1 chk(req_n === 1'b1, "R8 ce high releases", 32'(req_n), 32'h1);
    @(negedge clk) ce = 1'b0;
    #1 chk(req_n === 1'b0, "R8 request back", 32'(req_n), 32'h0);

    // R9 / R5: read done, now two corner keys held
    @(negedge clk) pressed = '0;
    pressed[kbit(1,1)] = 1'b1; pressed[kbit(6,5)] = 1'b1;
    rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
    chk(req_n === 1'b1, "R9 read clears request", 32'(req_n), 32'h1);
    wait_req(n);
    exp = '0; exp[kbit(1,1)] = 1'b1; exp[kbit(6,5)] = 1'b1;
    chk(n == CONF, "R9 new run after read", 32'(n), 32'(CONF));
    chk(key_data === exp, "R5 multiple keys", 32'(key_data), 32'(exp));

    // R9: released keys give an empty result
    @(negedge clk) pressed = '0;
    read_done();
    repeat (CONF + 10) @(posedge clk); @(negedge clk);
    chk(key_data === '0 && req_n === 1'b1, "R9 empty run clears", {key_data[30:0], req_n}, 32'h1);

    // R7: mismatching sweeps rerun the window
    @(negedge clk) pressed[kbit(6,3)] = 1'b1;
    repeat (400) @(posedge clk);
    @(negedge clk) pressed[kbit(5,1)] = 1'b1;
    wait_req(n);
    n += 400;
    exp = '0; exp[kbit(6,3)] = 1'b1; exp[kbit(5,1)] = 1'b1;
    chk(n == 2*CONF + 1, "R7 rerun timing", 32'(n), 32'(2*CONF + 1));
    chk(key_data === exp, "R7 rerun data", 32'(key_data), 32'(exp));
    settle();

    // R3 / R10: sleep code 01, only line 6 wakes
    @(negedge clk) sleep_code = 2'b01;
    @(negedge clk) pressed[kbit(1,3)] = 1'b1;
    repeat (1000) @(posedge clk); @(negedge clk);
    chk(req_n === 1'b1 && osc_en === 1'b0, "R3 low line ignored", {req_n, osc_en}, 32'h2);
    pressed[kbit(6,2)] = 1'b1;
    wait_req(n);
    exp = '0; exp[kbit(1,3)] = 1'b1; exp[kbit(6,2)] = 1'b1;
    chk(n == CONF + 1, "R3 wake timing", 32'(n), 32'(CONF + 1));
    chk(key_data === exp, "R3 wake data", 32'(key_data), 32'(exp));
    chk(sleep_ack === 1'b1 && osc_en === 1'b1, "R10 sleep press", {sleep_ack, osc_en}, 32'h3);
    settle();

    // R2: rows 1 and 2 given away
    @(negedge clk) begin sleep_code = 2'b00; seg_sel = 2'b10; end
    @(negedge clk) begin
      pressed[kbit(1,2)] = 1'b1; pressed[kbit(2,3)] = 1'b1; pressed[kbit(3,3)] = 1'b1;
    end
    wait_req(n);
    chk(key_data === (30'd1 << kbit(3,3)), "R2 given rows read zero", 32'(key_data), 32'd1 << kbit(3,3));

    // R11: reset during a pending request
    @(negedge clk) rst_n = 1'b0;
    #1 chk(req_n === 1'b1 && key_data === '0, "R11 reset clears", {key_data[30:0], req_n}, 32'h1);
    @(negedge clk) pressed = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (CONF + 10) @(posedge clk); @(negedge clk);
    chk(req_n === 1'b1 && scan_line === 6'h3C, "R11 standby after reset", {scan_line, req_n}, 32'h79);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule